// File: doc/BRIEF.md
# Burst column address generator

This block produces the column address for each beat of one memory burst. A read or write start strobe captures a start column together with the burst-length code, the ordering bit and the single-write option. From the next cycle on, the block presents the current column with a valid flag. Each cycle that the advance input is high moves it to the next column of the burst. The block also raises a flag on the final beat of a finite burst.

A length of 2, 4 or 8 keeps the burst inside an aligned block of that many columns. The column either counts upward and wraps inside the block, or it is scrambled by XOR with the beat number. A full-row burst counts through every column, wraps from the top column to column 0, and ends only on an explicit stop or a new start. A clock-suspend input freezes the block completely. A sticky error flag records any attempt to use an illegal length/ordering combination.

Top module: `burst_col_gen`

## Requirements
- R1: After synchronous reset, `col_valid`, `col_last` and `mode_err` are 0 and `col` is 0.
- R2: A start strobe (`start_rd` or `start_wr`) taken while `suspend` is low makes `col_valid` 1 and `col` equal to the captured `start_col` one clock later. A start overrides a stop or advance in the same cycle.
- R3: With `burst_ilv`=0 and `bl_code` 001, 010 or 011 (lengths 2, 4, 8), each advance adds 1 to the low log2(length) bits and wraps within them. The upper bits keep their start value, so length 4 from low bits 2 gives 2,3,0,1.
- R4: With `burst_ilv`=1 and `bl_code` 001, 010 or 011, the low bits on beat k equal the start low bits XOR k, so length 8 from 5 gives 5,4,7,6,1,0,3,2. The upper bits stay fixed.
- R5: `col_last` is 1 exactly while the final beat of a finite burst is shown. Advancing on that beat drops `col_valid` one clock later. Length 1 (`bl_code` 000) shows `col_last` on its first beat.
- R6: `bl_code` 111 with `burst_ilv`=0 is a full-row burst. The column increments across all bits, wraps from the top column to 0, and `col_last` never rises.
- R7: When `wr_single` is 1, a burst started by `start_wr` lasts one beat whatever `bl_code` says. A burst started by `start_rd` keeps the programmed length.
- R8: A `stop` without a start, taken while not suspended, makes `col_valid` and `col_last` 0 one clock later. No further addresses follow.
- R9: While `suspend` is high, `col`, `col_valid` and `col_last` hold their values, and start, stop and advance are ignored.
- R10: `bl_code` 100, 101 or 110, and `burst_ilv`=1 with `bl_code` 000 or 111, run as a one-beat burst and set `mode_err`. `mode_err` stays 1 until reset.
- R11: While a burst is valid and `advance` is low (and no start or stop), `col` and `col_last` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_rd | input | 1 | Start a read burst |
| start_wr | input | 1 | Start a write burst |
| start_col | input | COL_W | First column of the burst |
| bl_code | input | 3 | Burst-length code |
| burst_ilv | input | 1 | Ordering: 0 incrementing, 1 XOR-scrambled |
| wr_single | input | 1 | Writes last one beat when 1 |
| advance | input | 1 | Step to the next beat |
| stop | input | 1 | End the burst at once |
| suspend | input | 1 | Freeze all state this cycle |
| col | output | COL_W | Current column |
| col_valid | output | 1 | A burst beat is being shown |
| col_last | output | 1 | Current beat is the final one |
| mode_err | output | 1 | Sticky illegal-mode flag |

## Verification
Every result is registered. A start, stop or advance taken at one rising edge shows up on the outputs just after that edge, and a suspended edge leaves them unchanged. The bench changes inputs only at the falling edge and compares the outputs at the next falling edge with a behavioural model. The model updates on the same rising edge, so each comparison falls exactly one cycle after its stimulus. Hard-coded column sequences for the ordering and wrap cases are checked at those same sample points.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    BL_ONE   = 3'b000,
    BL_TWO   = 3'b001,
    BL_FOUR  = 3'b010,
    BL_EIGHT = 3'b011,
    BL_ROW   = 3'b111
  } bl_code_e;

  typedef enum logic {
    ORDER_INC = 1'b0,
    ORDER_XOR = 1'b1
  } order_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
  import bcg_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [CODE_W-1:0] code,
  input  logic              order_xor,
  input  logic              force_one,
  output logic [COL_W-1:0]  mask,
  output logic              row_mode,
  output logic              illegal
);
  localparam logic [COL_W-1:0] ALL_ONES = '1;

  always_comb begin
    mask     = '0;
    row_mode = 1'b0;
    illegal  = 1'b0;
    if (!force_one) begin
      case (code)
        BL_ONE:   illegal = (order_xor == ORDER_XOR);
        BL_TWO:   mask = COL_W'(1);
        BL_FOUR:  mask = COL_W'(3);
        BL_EIGHT: mask = COL_W'(7);
        BL_ROW: begin
          if (order_xor == ORDER_XOR) begin
            illegal = 1'b1;
          end else begin
            mask     = ALL_ONES;
            row_mode = 1'b1;
          end
        end
        default:  illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/bcg_next_addr.sv
module bcg_next_addr #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] cur_col,
  input  logic [COL_W-1:0] first_col,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             order_xor,
  output logic [COL_W-1:0] nxt_col
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic [COL_W-1:0] inc_low;
  logic [COL_W-1:0] xor_low;
  logic [COL_W-1:0] beat_nxt;

  always_comb begin
    beat_nxt = beat + ONE;
    inc_low  = (cur_col + ONE) & mask;
    xor_low  = (first_col ^ beat_nxt) & mask;
    if (order_xor)
      nxt_col = (first_col & ~mask) | xor_low;
    else
      nxt_col = (cur_col & ~mask) | inc_low;
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_rd,
  input  logic              start_wr,
  input  logic [COL_W-1:0]  start_col,
  input  logic [CODE_W-1:0] bl_code,
  input  logic              burst_ilv,
  input  logic              wr_single,
  input  logic              advance,
  input  logic              stop,
  input  logic              suspend,
  output logic [COL_W-1:0]  col,
  output logic              col_valid,
  output logic              col_last,
  output logic              mode_err
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic             launch;
  logic [COL_W-1:0] dec_mask;
  logic             dec_row;
  logic             dec_bad;
  logic [COL_W-1:0] nxt_col;

  logic [COL_W-1:0] first_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  logic             row_q;
  logic             xor_q;

  assign launch = start_rd | start_wr;

  bcg_len_decode #(.COL_W(COL_W)) dec_i (
    .code      (bl_code),
    .order_xor (burst_ilv),
    .force_one (start_wr & wr_single),
    .mask      (dec_mask),
    .row_mode  (dec_row),
    .illegal   (dec_bad)
  );

  bcg_next_addr #(.COL_W(COL_W)) step_i (
    .cur_col   (col),
    .first_col (first_q),
    .beat      (beat_q),
    .mask      (mask_q),
    .order_xor (xor_q),
    .nxt_col   (nxt_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col       <= '0;
      col_valid <= 1'b0;
      col_last  <= 1'b0;
      mode_err  <= 1'b0;
      first_q   <= '0;
      beat_q    <= '0;
      mask_q    <= '0;
      row_q     <= 1'b0;
      xor_q     <= 1'b0;
    end else if (!suspend) begin
      if (launch) begin
        col       <= start_col;
        first_q   <= start_col;
        beat_q    <= '0;
        mask_q    <= dec_mask;
        row_q     <= dec_row;
        xor_q     <= burst_ilv;
        col_valid <= 1'b1;
        col_last  <= (dec_mask == '0);
        if (dec_bad)
          mode_err <= 1'b1;
      end else if (stop) begin
        col_valid <= 1'b0;
        col_last  <= 1'b0;
      end else if (col_valid && advance) begin
        if (col_last) begin
          col_valid <= 1'b0;
          col_last  <= 1'b0;
        end else begin
          col      <= nxt_col;
          beat_q   <= beat_q + ONE;
          col_last <= !row_q && ((beat_q + ONE) == mask_q);
        end
      end
    end
  end
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start_rd,
  input logic             start_wr,
  input logic [COL_W-1:0] start_col,
  input logic             advance,
  input logic             stop,
  input logic             suspend,
  input logic [COL_W-1:0] col,
  input logic             col_valid,
  input logic             col_last,
  input logic             mode_err
);
  assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
    ((start_rd || start_wr) && !suspend) |=> (col_valid && col == $past(start_col)));

  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (rst)
    (stop && !start_rd && !start_wr && !suspend) |=> (!col_valid && !col_last));

  assert_suspend_holds_R9: assert property (@(posedge clk) disable iff (rst)
    suspend |=> ($stable(col) && $stable(col_valid) && $stable(col_last)));

  assert_last_needs_valid_R5: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    mode_err |=> mode_err);

  assert_no_step_R11: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !advance && !start_rd && !start_wr && !stop) |=>
      ($stable(col) && $stable(col_last)));
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .start_rd  (start_rd),
  .start_wr  (start_wr),
  .start_col (start_col),
  .advance   (advance),
  .stop      (stop),
  .suspend   (suspend),
  .col       (col),
  .col_valid (col_valid),
  .col_last  (col_last),
  .mode_err  (mode_err)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb_top;
  localparam int COL_W = 10;
  localparam int NCOL  = 1 << COL_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_rd = 1'b0, start_wr = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0] bl_code = 3'b000;
  logic burst_ilv = 1'b0, wr_single = 1'b0;
  logic advance = 1'b0, stop = 1'b0, suspend = 1'b0;
  logic [COL_W-1:0] col;
  logic col_valid, col_last, mode_err;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .start_rd(start_rd), .start_wr(start_wr),
    .start_col(start_col), .bl_code(bl_code), .burst_ilv(burst_ilv),
    .wr_single(wr_single), .advance(advance), .stop(stop), .suspend(suspend),
    .col(col), .col_valid(col_valid), .col_last(col_last), .mode_err(mode_err)
  );

  // behavioural reference
  int m_col = 0, m_first = 0, m_beat = 0, m_len = 1;
  bit m_valid = 0, m_last = 0, m_err = 0, m_xor = 0;

  function automatic int addr_of(int first, int beat, int len, bit xr);
    int base, off;
    if (len == 0) return (first + beat) % NCOL;
    base = first - (first % len);
    off  = first % len;
    if (xr) return base + (off ^ beat);
    return base + ((off + beat) % len);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 0; m_last = 0; m_err = 0; m_col = 0;
    end else if (!suspend) begin
      if (start_rd || start_wr) begin
        if (start_wr && wr_single) m_len = 1;
        else begin
          case (bl_code)
            3'b000: begin m_len = 1; if (burst_ilv) m_err = 1; end
            3'b001: m_len = 2;
            3'b010: m_len = 4;
            3'b011: m_len = 8;
            3'b111: begin
              if (burst_ilv) begin m_len = 1; m_err = 1; end
              else m_len = 0;
            end
            default: begin m_len = 1; m_err = 1; end
          endcase
        end
        m_first = start_col; m_beat = 0; m_xor = burst_ilv;
        m_col = start_col; m_valid = 1; m_last = (m_len == 1);
      end else if (stop) begin
        m_valid = 0; m_last = 0;
      end else if (m_valid && advance) begin
        if (m_last) begin
          m_valid = 0; m_last = 0;
        end else begin
          m_beat++;
          m_col = addr_of(m_first, m_beat, m_len, m_xor);
          m_last = (m_len != 0) && (m_beat == m_len - 1);
        end
      end
    end
  end

  task automatic fail_line(string tag, string what, int act, int exp);
    n_fail++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  task automatic compare(string tag);
    n_chk++;
    if (col_valid !== m_valid) fail_line(tag, "col_valid", col_valid, m_valid);
    else if (col_last !== m_last) fail_line(tag, "col_last", col_last, m_last);
    else if (mode_err !== m_err) fail_line(tag, "mode_err", mode_err, m_err);
    else if (m_valid && col !== m_col) fail_line(tag, "col", col, m_col);
  endtask

  task automatic expect_col(string tag, int exp);
    n_chk++;
    if (col_valid !== 1'b1 || col !== exp) fail_line(tag, "col", col, exp);
  endtask

  task automatic idle_inputs();
    start_rd = 0; start_wr = 0; advance = 0; stop = 0; suspend = 0;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    idle_inputs();
  endtask

  task automatic launch(bit wr, int c, bit [2:0] code, bit ilv, string tag);
    start_rd = !wr; start_wr = wr; start_col = c[COL_W-1:0];
    bl_code = code; burst_ilv = ilv;
    step(tag);
  endtask

  task automatic adv(string tag);
    advance = 1; step(tag);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    fail_line("R1", "watchdog", 1, 0);
    report();
  end

  initial begin
    @(negedge clk);
    repeat (3) step("R1");
    n_chk++;
    if (col !== '0 || col_valid !== 0 || col_last !== 0 || mode_err !== 0)
      fail_line("R1", "reset outputs", {col_valid, col_last, mode_err}, 0);
    rst = 0;
    step("R1");

    // R3 incrementing length 4 from low bits 2
    launch(0, 'h12A, 3'b010, 0, "R3"); expect_col("R3", 'h12A);
    adv("R3"); expect_col("R3", 'h12B);
    adv("R3"); expect_col("R3", 'h128);
    adv("R3"); expect_col("R3", 'h129);
    n_chk++; if (col_last !== 1) fail_line("R5", "last on beat 4", col_last, 1);
    adv("R5");
    n_chk++; if (col_valid !== 0) fail_line("R5", "valid after end", col_valid, 0);

    // R4 XOR order length 8 from 5
    begin
      int exp8[8] = '{'h2C5, 'h2C4, 'h2C7, 'h2C6, 'h2C1, 'h2C0, 'h2C3, 'h2C2};
      launch(0, 'h2C5, 3'b011, 1, "R4"); expect_col("R4", exp8[0]);
      for (int i = 1; i < 8; i++) begin adv("R4"); expect_col("R4", exp8[i]); end
      adv("R5");
    end

    // R3 length 2 odd start, R4 length 4 XOR
    launch(1, 'h0F3, 3'b001, 0, "R3"); adv("R3"); expect_col("R3", 'h0F2); adv("R5");
    launch(0, 'h046, 3'b010, 1, "R4");
    for (int i = 0; i < 4; i++) adv("R4");

    // R11 gaps in advance on length 8
    launch(0, 'h19D, 3'b011, 0, "R11");
    for (int i = 0; i < 12; i++) begin advance = (i % 3 == 0); step("R11"); end

    // R5 length 1
    launch(0, 'h077, 3'b000, 0, "R5");
    n_chk++; if (col_last !== 1) fail_line("R5", "len1 last", col_last, 1);
    adv("R5");

    // R6 full row wraps past top
    launch(0, 'h3FE, 3'b111, 0, "R6");
    adv("R6"); expect_col("R6", 'h3FF);
    adv("R6"); expect_col("R6", 'h000);
    adv("R6"); expect_col("R6", 'h001);
    for (int i = 0; i < 20; i++) adv("R6");
    stop = 1; step("R8");
    n_chk++; if (col_valid !== 0) fail_line("R8", "stop ends row burst", col_valid, 0);

    // R7 single write
    wr_single = 1;
    launch(1, 'h200, 3'b011, 0, "R7");
    n_chk++; if (col_last !== 1) fail_line("R7", "single write last", col_last, 1);
    adv("R7");
    launch(0, 'h200, 3'b011, 0, "R7");
    for (int i = 0; i < 8; i++) adv("R7");
    wr_single = 0;

    // R8 stop mid burst, then start+stop same cycle
    launch(0, 'h150, 3'b011, 0, "R8"); adv("R8"); stop = 1; step("R8");
    adv("R8");
    stop = 1; launch(0, 'h155, 3'b010, 0, "R2"); expect_col("R2", 'h155);
    adv("R2"); adv("R2"); adv("R2"); adv("R2");

    // R9 suspend holds, start ignored
    launch(0, 'h0A0, 3'b011, 1, "R9"); adv("R9");
    suspend = 1; advance = 1; step("R9"); expect_col("R9", 'h0A1);
    suspend = 1; start_rd = 1; start_col = 'h333; step("R9");
    suspend = 1; stop = 1; step("R9");
    for (int i = 0; i < 8; i++) adv("R9");

    // R10 illegal codes
    launch(0, 'h111, 3'b101, 0, "R10");
    n_chk++; if (mode_err !== 1) fail_line("R10", "err after 101", mode_err, 1);
    adv("R10");
    launch(0, 'h222, 3'b010, 0, "R10");
    for (int i = 0; i < 4; i++) adv("R10");
    launch(0, 'h040, 3'b111, 1, "R10"); adv("R10");
    launch(0, 'h041, 3'b000, 1, "R10"); adv("R10");
    rst = 1; step("R1"); rst = 0; step("R1");
    launch(0, 'h300, 3'b110, 0, "R10"); adv("R10"); step("R10");

    report();
  end
endmodule